// File: doc/BRIEF.md
# Shadowed Control and Status Register Bank

This block is a small register bank for a host-programmed datapath. It holds three kinds of bit. Shadowed configuration words have a pending copy that the host writes and an active copy that drives the datapath. Status words are set by hardware events and cleared by the host writing ones. Read-only words reflect hardware inputs directly. A per-status-word mask register gates the status bits into a single interrupt line.

Host writes to a configuration address change only its pending copy, so software can rewrite it as often as it likes. A rising edge on the update request input passes through a synchronizer into the owning clock. The resulting one-cycle strobe copies every pending word into its active copy at the same clock edge, so the datapath sees a consistent set of values.

The two resets differ. The asynchronous hardware reset clears everything. The synchronous software reset clears only the active copies and the status words. Pending copies and masks keep their values through a software reset.

Top module: `shadowRegBank`

## Requirements
- R1: A host write to a configuration address (0 to 3) loads wrData into that word's pending copy, visible on rdData with rdActive low right after the write edge. The write leaves actOut unchanged.
- R2: A rising edge on updReq copies all pending words into the active copies on the third rising clock edge after updReq is first sampled high (SYNC_STAGES+1). Word i drives actOut[i*DATA_W +: DATA_W]. actOut changes on no other edge, and holding updReq high triggers no further loads. If a pending write and the load land on the same edge, the active copy takes the old pending value.
- R3: A synchronous software reset (swRst high at an edge) sets every active word to ACT_INIT (zero by default) and clears all status bits. Pending copies and mask words are left unchanged.
- R4: An asynchronous hardware reset (hwRstN low) clears the pending, active, mask and status storage; active words return to ACT_INIT.
- R5: A status word (addresses 4 and 5) sets each bit one edge after the matching bit of hwStatSet is high. hwStatSet word w is bits [w*DATA_W +: DATA_W]. A host write clears exactly the bits written as 1 and leaves bits written as 0 unchanged.
- R6: If a hardware set and a host write-one-to-clear hit the same status bit on one edge, the bit ends set. A software reset on the same edge as a hardware set leaves the bit clear.
- R7: Read-only addresses 8 and 9 return words 0 and 1 of hwRoIn. Writes to them change no register.
- R8: With rdActive high, a read of a configuration address returns the active copy instead of the pending copy.
- R9: irqOut is high exactly when some status bit is set whose bit in the mask word at the same index (mask words at addresses 6 and 7) is also set. Mask words are plain read/write registers.
- R10: Reads of unmapped addresses (10 to 15) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the owning domain |
| hwRstN | input | 1 | Asynchronous hardware reset, active low |
| swRst | input | 1 | Synchronous software reset, active high |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W | Host write word address |
| wrData | input | DATA_W | Host write data |
| rdAddr | input | ADDR_W | Host read word address |
| rdActive | input | 1 | Selects the active copy on configuration reads |
| rdData | output | DATA_W | Host read data, combinational from rdAddr |
| updReq | input | 1 | Update request; a rising edge loads the active copies |
| hwStatSet | input | STAT_WORDS*DATA_W | Per-bit hardware status set pulses |
| hwRoIn | input | RO_WORDS*DATA_W | Hardware values shown at the read-only addresses |
| actOut | output | CFG_WORDS*DATA_W | Active configuration words to the datapath |
| irqOut | output | 1 | OR of masked status bits |

## Verification
Every configuration word is swept with all-zero, all-one and two alternating patterns, each offset per word. The sweep shows that pending and active copies are separate, that the load waits exactly for the synchronizer latency, and that words are not aliased. Status bits are walked one at a time and then cleared with partial masks, which separates write-one-to-clear from plain writes. Same-edge collisions of set with clear, and of set with software reset, show which side has priority. Back-to-back software and hardware resets over a populated bank show which storage each reset reaches.

// File: rtl/shadowRegPkg.sv
package shadowRegPkg;
  // Word counts of the bank; the strobe struct below is sized from them.
  localparam int CFG_WORDS  = 4;
  localparam int STAT_WORDS = 2;
  localparam int RO_WORDS   = 2;
  localparam int STAT_BASE  = CFG_WORDS;
  localparam int MASK_BASE  = STAT_BASE + STAT_WORDS;
  localparam int RO_BASE    = MASK_BASE + STAT_WORDS;
  localparam int USED_WORDS = RO_BASE + RO_WORDS;

  // Strobes from the decode/control side to the storage side.
  typedef struct packed {
    logic [CFG_WORDS-1:0]  pendWe;
    logic [STAT_WORDS-1:0] statClr;
    logic [STAT_WORDS-1:0] maskWe;
    logic                  update;
  } regStrobe_t;
endpackage

// File: rtl/regBankCtrl.sv
module regBankCtrl
  import shadowRegPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              updReq,
  output regStrobe_t        strb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   edgeQ;
  logic                   updPulse;

  // Synchronizer chain for the update request.
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge hwRstN) begin
        if (!hwRstN) syncQ <= '0;
        else         syncQ <= updReq;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge hwRstN) begin
        if (!hwRstN) syncQ <= '0;
        else         syncQ <= {syncQ[SYNC_STAGES-2:0], updReq};
      end
    end
  endgenerate

  // Edge detector: one strobe per rising edge of the synchronized request.
  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) edgeQ <= 1'b0;
    else         edgeQ <= syncQ[SYNC_STAGES-1];
  end

  assign updPulse = syncQ[SYNC_STAGES-1] & ~edgeQ;

  // Address decode into per-word write strobes.
  always_comb begin
    strb = '0;
    strb.update = updPulse;
    for (int i = 0; i < CFG_WORDS; i++) begin
      if (wrEn && wrAddr == ADDR_W'(i)) strb.pendWe[i] = 1'b1;
    end
    for (int i = 0; i < STAT_WORDS; i++) begin
      if (wrEn && wrAddr == ADDR_W'(STAT_BASE + i)) strb.statClr[i] = 1'b1;
      if (wrEn && wrAddr == ADDR_W'(MASK_BASE + i)) strb.maskWe[i]  = 1'b1;
    end
  end
endmodule

// File: rtl/regBankData.sv
module regBankData
  import shadowRegPkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 4,
  parameter logic [DATA_W-1:0] ACT_INIT = '0
) (
  input  logic                         clk,
  input  logic                         hwRstN,
  input  logic                         swRst,
  input  regStrobe_t                   strb,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [ADDR_W-1:0]            rdAddr,
  input  logic                         rdActive,
  input  logic [STAT_WORDS*DATA_W-1:0] hwStatSet,
  input  logic [RO_WORDS*DATA_W-1:0]   hwRoIn,
  output logic [DATA_W-1:0]            rdData,
  output logic [CFG_WORDS*DATA_W-1:0]  actOut,
  output logic [CFG_WORDS*DATA_W-1:0]  pendFlat,
  output logic [STAT_WORDS*DATA_W-1:0] statFlat,
  output logic [STAT_WORDS*DATA_W-1:0] maskFlat,
  output logic                         irqOut
);
  // Shadowed configuration words.
  for (genvar g = 0; g < CFG_WORDS; g++) begin : gCfg
    logic [DATA_W-1:0] pendQ;
    logic [DATA_W-1:0] actQ;

    always_ff @(posedge clk or negedge hwRstN) begin
      if (!hwRstN)             pendQ <= '0;
      else if (strb.pendWe[g]) pendQ <= wrData;
    end

    always_ff @(posedge clk or negedge hwRstN) begin
      if (!hwRstN)          actQ <= ACT_INIT;
      else if (swRst)       actQ <= ACT_INIT;
      else if (strb.update) actQ <= pendQ;
    end

    assign pendFlat[g*DATA_W +: DATA_W] = pendQ;
    assign actOut[g*DATA_W +: DATA_W]   = actQ;
  end

  // Status words (hardware set, host write-one-to-clear) and their masks.
  for (genvar g = 0; g < STAT_WORDS; g++) begin : gStat
    logic [DATA_W-1:0] statQ;
    logic [DATA_W-1:0] maskQ;
    logic [DATA_W-1:0] clrBits;
    logic [DATA_W-1:0] setBits;

    assign clrBits = strb.statClr[g] ? wrData : '0;
    assign setBits = hwStatSet[g*DATA_W +: DATA_W];

    always_ff @(posedge clk or negedge hwRstN) begin
      if (!hwRstN)    statQ <= '0;
      else if (swRst) statQ <= '0;
      else            statQ <= (statQ & ~clrBits) | setBits;
    end

    always_ff @(posedge clk or negedge hwRstN) begin
      if (!hwRstN)             maskQ <= '0;
      else if (strb.maskWe[g]) maskQ <= wrData;
    end

    assign statFlat[g*DATA_W +: DATA_W] = statQ;
    assign maskFlat[g*DATA_W +: DATA_W] = maskQ;
  end

  assign irqOut = |(statFlat & maskFlat);

  // Read multiplexer; unmapped addresses read zero.
  always_comb begin
    rdData = '0;
    for (int i = 0; i < CFG_WORDS; i++) begin
      if (rdAddr == ADDR_W'(i)) begin
        rdData = rdActive ? actOut[i*DATA_W +: DATA_W] : pendFlat[i*DATA_W +: DATA_W];
      end
    end
    for (int i = 0; i < STAT_WORDS; i++) begin
      if (rdAddr == ADDR_W'(STAT_BASE + i)) rdData = statFlat[i*DATA_W +: DATA_W];
      if (rdAddr == ADDR_W'(MASK_BASE + i)) rdData = maskFlat[i*DATA_W +: DATA_W];
    end
    for (int i = 0; i < RO_WORDS; i++) begin
      if (rdAddr == ADDR_W'(RO_BASE + i)) rdData = hwRoIn[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/shadowRegBank.sv
module shadowRegBank
  import shadowRegPkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ACT_INIT    = '0
) (
  input  logic                         clk,
  input  logic                         hwRstN,
  input  logic                         swRst,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [ADDR_W-1:0]            rdAddr,
  input  logic                         rdActive,
  output logic [DATA_W-1:0]            rdData,
  input  logic                         updReq,
  input  logic [STAT_WORDS*DATA_W-1:0] hwStatSet,
  input  logic [RO_WORDS*DATA_W-1:0]   hwRoIn,
  output logic [CFG_WORDS*DATA_W-1:0]  actOut,
  output logic                         irqOut
);
  regStrobe_t                   strb;
  logic [CFG_WORDS*DATA_W-1:0]  pendFlat;
  logic [STAT_WORDS*DATA_W-1:0] statFlat;
  logic [STAT_WORDS*DATA_W-1:0] maskFlat;

  regBankCtrl #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrlI (
    .clk    (clk),
    .hwRstN (hwRstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .updReq (updReq),
    .strb   (strb)
  );

  regBankData #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ACT_INIT (ACT_INIT)
  ) dataI (
    .clk       (clk),
    .hwRstN    (hwRstN),
    .swRst     (swRst),
    .strb      (strb),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdActive  (rdActive),
    .hwStatSet (hwStatSet),
    .hwRoIn    (hwRoIn),
    .rdData    (rdData),
    .actOut    (actOut),
    .pendFlat  (pendFlat),
    .statFlat  (statFlat),
    .maskFlat  (maskFlat),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/shadowRegBankChk.sv
module shadowRegBankChk
  import shadowRegPkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 4,
  parameter logic [DATA_W-1:0] ACT_INIT = '0
) (
  input logic                         clk,
  input logic                         hwRstN,
  input logic                         swRst,
  input logic                         wrEn,
  input logic [ADDR_W-1:0]            wrAddr,
  input logic                         updStrobe,
  input logic [STAT_WORDS*DATA_W-1:0] hwStatSet,
  input logic [CFG_WORDS*DATA_W-1:0]  actOut,
  input logic [CFG_WORDS*DATA_W-1:0]  pendFlat,
  input logic [STAT_WORDS*DATA_W-1:0] statFlat,
  input logic [STAT_WORDS*DATA_W-1:0] maskFlat,
  input logic                         irqOut
);
  logic roWrite;
  assign roWrite = wrEn && (wrAddr >= ADDR_W'(RO_BASE)) && (wrAddr < ADDR_W'(USED_WORDS));

  // R2: active copies move only on an update strobe (or a software reset).
  assert_act_hold_R2: assert property (@(posedge clk) disable iff (!hwRstN)
    (!updStrobe && !swRst) |=> $stable(actOut));

  // R3: software reset returns active words to their default and clears status.
  assert_swrst_clear_R3: assert property (@(posedge clk) disable iff (!hwRstN)
    swRst |=> (actOut == {CFG_WORDS{ACT_INIT}}) && (statFlat == '0));

  // R3: software reset without a host write keeps pending copies and masks.
  assert_swrst_keep_R3: assert property (@(posedge clk) disable iff (!hwRstN)
    (swRst && !wrEn) |=> $stable(pendFlat) && $stable(maskFlat));

  // R6: a hardware set lands even against a same-edge host clear.
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!hwRstN)
    (!swRst && (hwStatSet != '0)) |=> ((statFlat & $past(hwStatSet)) == $past(hwStatSet)));

  // R7: writes to read-only addresses leave stored words alone.
  assert_ro_nowrite_R7: assert property (@(posedge clk) disable iff (!hwRstN)
    roWrite |=> $stable(pendFlat) && $stable(maskFlat));

  // R9: no status bit set means no interrupt.
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!hwRstN)
    (statFlat == '0) |-> !irqOut);
endmodule

bind shadowRegBank shadowRegBankChk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .ACT_INIT (ACT_INIT)
) chkI (
  .clk       (clk),
  .hwRstN    (hwRstN),
  .swRst     (swRst),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .updStrobe (strb.update),
  .hwStatSet (hwStatSet),
  .actOut    (actOut),
  .pendFlat  (pendFlat),
  .statFlat  (statFlat),
  .maskFlat  (maskFlat),
  .irqOut    (irqOut)
);

// File: tb/shadowRegBank_tb.sv
module shadowRegBank_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NCFG = 4;
  localparam int NSTAT = 2;
  localparam int NRO = 2;

  logic clk = 1'b0;
  logic hwRstN = 1'b0;
  logic swRst = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic rdActive = 1'b0;
  logic [DW-1:0] rdData;
  logic updReq = 1'b0;
  logic [NSTAT*DW-1:0] hwStatSet = '0;
  logic [NRO*DW-1:0] hwRoIn = 16'hA55A;
  logic [NCFG*DW-1:0] actOut;
  logic irqOut;

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] pendM [NCFG];
  logic [DW-1:0] actM  [NCFG];
  logic [DW-1:0] statM [NSTAT];
  logic [DW-1:0] maskM [NSTAT];

  always #4 clk = ~clk;

  shadowRegBank dut_i (
    .clk(clk), .hwRstN(hwRstN), .swRst(swRst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdActive(rdActive), .rdData(rdData),
    .updReq(updReq), .hwStatSet(hwStatSet), .hwRoIn(hwRoIn), .actOut(actOut),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic readChk(input logic [AW-1:0] a, input logic act, input logic [DW-1:0] exp,
                         input string req);
    rdAddr = a;
    rdActive = act;
    #1;
    chk(req, {24'h0, rdData}, {24'h0, exp});
  endtask

  task automatic actChk(input string req);
    for (int i = 0; i < NCFG; i++) chk(req, {24'h0, actOut[i*DW +: DW]}, {24'h0, actM[i]});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Raise updReq; active copies load on the third edge after first sampling.
  task automatic upd();
    @(negedge clk);
    updReq = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    actChk("R2 before load");
    @(negedge clk);
    for (int i = 0; i < NCFG; i++) actM[i] = pendM[i];
    actChk("R2 after load");
    // Hold high: no second load even with a new pending value.
    pendM[0] = pendM[0] ^ 8'h3C;
    wrEn = 1'b1; wrAddr = '0; wrData = pendM[0];
    @(negedge clk);
    wrEn = 1'b0;
    repeat (4) @(negedge clk);
    actChk("R2 held request");
    updReq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fullRead(input string req);
    for (int i = 0; i < NCFG; i++)  readChk(AW'(i), 1'b0, pendM[i], req);
    for (int i = 0; i < NSTAT; i++) readChk(AW'(4 + i), 1'b0, statM[i], req);
    for (int i = 0; i < NSTAT; i++) readChk(AW'(6 + i), 1'b0, maskM[i], req);
    for (int i = 0; i < NRO; i++)   readChk(AW'(8 + i), 1'b0, hwRoIn[i*DW +: DW], "R7 ro read");
    for (int i = 10; i < 16; i++)   readChk(AW'(i), 1'b0, 8'h00, "R10 unmapped read");
  endtask

  task automatic pulseSet(input int w, input logic [DW-1:0] bits);
    @(negedge clk);
    hwStatSet = '0;
    hwStatSet[w*DW +: DW] = bits;
    @(negedge clk);
    hwStatSet = '0;
    statM[w] = statM[w] | bits;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCFG; i++) begin pendM[i] = 0; actM[i] = 0; end
    for (int i = 0; i < NSTAT; i++) begin statM[i] = 0; maskM[i] = 0; end
    #20;
    @(negedge clk);
    hwRstN = 1'b1;
    @(negedge clk);
    // Reset state (R4)
    actChk("R4 reset active");
    chk("R4 reset irq", {31'h0, irqOut}, 32'h0);
    fullRead("R4 reset read");

    // R1/R2/R8: pattern sweep over every configuration word
    begin
      logic [DW-1:0] pats [4];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < NCFG; i++) begin
          pendM[i] = pats[p] ^ DW'(i * 17 + p);
          wr(AW'(i), pendM[i]);
          readChk(AW'(i), 1'b0, pendM[i], "R1 pending readback");
          actChk("R1 active untouched");
        end
        upd();
        for (int i = 0; i < NCFG; i++) readChk(AW'(i), 1'b1, actM[i], "R8 active readback");
        readChk(AW'(0), 1'b0, pendM[0], "R8 pending differs");
      end
    end

    // R5: walk single status bits, then partial write-one-to-clear
    for (int w = 0; w < NSTAT; w++) begin
      for (int b = 0; b < DW; b++) begin
        pulseSet(w, DW'(1) << b);
        readChk(AW'(4 + w), 1'b0, statM[w], "R5 set bit");
      end
      wr(AW'(4 + w), 8'h00);
      readChk(AW'(4 + w), 1'b0, statM[w], "R5 write zero keeps");
      wr(AW'(4 + w), 8'h0F);
      statM[w] = statM[w] & 8'hF0;
      readChk(AW'(4 + w), 1'b0, statM[w], "R5 partial clear");
      wr(AW'(4 + w), 8'hF0);
      statM[w] = 8'h00;
      readChk(AW'(4 + w), 1'b0, statM[w], "R5 full clear");
    end

    // R6: set beats same-edge clear
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd4; wrData = 8'h08;
    hwStatSet = 16'h0008;
    @(negedge clk);
    wrEn = 1'b0; hwStatSet = '0;
    statM[0] = 8'h08;
    readChk(4'd4, 1'b0, statM[0], "R6 set wins over clear");

    // R9: masked interrupt
    pulseSet(1, 8'h01);
    chk("R9 irq masked off", {31'h0, irqOut}, 32'h1 & {31'h0, |(maskM[0] & statM[0])});
    maskM[1] = 8'h01; wr(4'd7, maskM[1]);
    chk("R9 irq enabled", {31'h0, irqOut}, 32'h1);
    maskM[1] = 8'h02; wr(4'd7, maskM[1]);
    chk("R9 irq other bit", {31'h0, irqOut}, 32'h0);
    maskM[0] = 8'h08; wr(4'd6, maskM[0]);
    chk("R9 irq word0", {31'h0, irqOut}, 32'h1);
    readChk(4'd6, 1'b0, maskM[0], "R9 mask readback");

    // R7 and R10: writes to read-only and unmapped addresses
    wr(4'd8, 8'hFF); wr(4'd9, 8'h00);
    for (int i = 10; i < 16; i++) wr(AW'(i), 8'hC3);
    fullRead("R7 R10 no side effect");

    // R6: software reset beats a same-edge set; R3 reset reach
    pendM[2] = 8'h77; wr(4'd2, pendM[2]);
    @(negedge clk);
    swRst = 1'b1; hwStatSet = 16'hFFFF;
    @(negedge clk);
    swRst = 1'b0; hwStatSet = '0;
    for (int i = 0; i < NCFG; i++) actM[i] = 8'h00;
    statM[0] = 0; statM[1] = 0;
    actChk("R3 active cleared");
    readChk(4'd4, 1'b0, 8'h00, "R6 reset beats set");
    chk("R3 irq after swrst", {31'h0, irqOut}, 32'h0);
    fullRead("R3 pending and mask kept");
    upd();

    // R4: asynchronous hardware reset
    #2;
    hwRstN = 1'b0;
    #1;
    for (int i = 0; i < NCFG; i++) begin pendM[i] = 0; actM[i] = 0; end
    for (int i = 0; i < NSTAT; i++) begin statM[i] = 0; maskM[i] = 0; end
    actChk("R4 hw reset active");
    readChk(4'd1, 1'b0, 8'h00, "R4 hw reset pending");
    readChk(4'd6, 1'b0, 8'h00, "R4 hw reset mask");
    @(negedge clk);
    hwRstN = 1'b1;
    @(negedge clk);
    fullRead("R4 after hw reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule